// File: doc/BRIEF.md
# Six-Channel Low-Side Driver Control Core

This block is the digital heart of a six-channel low-side switch. A host writes an 8-bit command over a four-wire serial link. Six command bits request the six gate drives, and the top bit asks for a low-power state. The core merges the command with three direct-drive inputs and a global inhibit input. It then maps the result onto the six gate-enable outputs using one of two schemes. In the independent scheme each output has its own control. In the paired scheme the outputs act as two ganged groups of three.

While a command is being shifted in, the core shifts out a snapshot of latched per-channel fault flags. It captures these flags when the transfer starts. Each flag is set by a one-cycle pulse from the analog sense circuits, and it stays set until a transfer has reported it. All serial pins are brought into the core clock domain through a synchronizer of configurable depth. Every serial event is therefore a clocked edge event inside the core.

Top module: `lsw_ctrl_core`

## Requirements
- R1: After reset all gate enables are 0, the low-power output is 0, the serial output enable is 0, and the applied command is all zeros.
- R2: In independent mode (pair_mode_i=0) with inhibit low, gate k for k=0,1,2 is on when command bit k or direct input k is 1.
- R3: In independent mode with inhibit low, gates 3, 4 and 5 equal command bits 3, 4 and 5, and the direct inputs have no effect on them.
- R4: In paired mode (pair_mode_i=1) with inhibit low, gates 0, 4 and 5 are all on when direct input 0 is 1 or when command bits 0, 4 and 5 are all 1, and are all off otherwise.
- R5: In paired mode with inhibit low, gates 1, 2 and 3 are all on when direct input 1 is 1 or when command bits 1, 2 and 3 are all 1, and are all off otherwise; direct input 2 has no effect in this mode.
- R6: While inhibit_i is 1, every gate enable is 0 whatever the command and direct inputs are.
- R7: The low-power output is 1 exactly when inhibit_i is 1 and bit 7 of the applied command is 1.
- R8: Data input is sampled on rising serial-clock edges, MSB first. The received word becomes the applied command when chip select rises, and only if exactly 8 rising clocks were seen while chip select was low. With any other count the previous command stays in place.
- R9: The serial output enable is 0 while chip select is high. During a transfer the output word is presented MSB first, and it advances to the next bit on each falling serial-clock edge.
- R10: A fault pulse on channel k sets a sticky flag. The flags are captured when chip select falls and are returned as output word bits 0 to 5 (channel 0 in bit 0). Bits 6 and 7 read 0.
- R11: Captured flags are cleared. A fault pulse present on the capture cycle, or any later pulse, sets its flag again, so a fault that persists shows in every following transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_cs_ni | input | 1 | Serial chip select, active low |
| spi_sclk_i | input | 1 | Serial clock |
| spi_sdi_i | input | 1 | Serial data in |
| spi_sdo_o | output | 1 | Serial data out |
| spi_sdo_oe_o | output | 1 | Output enable for the serial data pad |
| direct_on_i | input | 3 | Direct-drive inputs for channels 0..2 or for the two groups |
| inhibit_i | input | 1 | Global inhibit; forces all gates off |
| pair_mode_i | input | 1 | 1 selects paired mapping, 0 independent |
| fault_det_i | input | 6 | Per-channel fault pulses from sense circuits |
| gate_on_o | output | 6 | Gate enables for the six channels |
| low_power_o | output | 1 | Low-power request to the analog blocks |

## Verification
The bench builds the core with a three-stage synchronizer rather than the default two. The reference model therefore has to account for a command-apply latency of four core cycles after chip select rises, and a mismatch in the synchronizer depth or in the edge-detect pipeline shows up as a one-cycle disagreement on the gate outputs. The paired mapping is left enabled, so that both the independent and the ganged gate equations are reached. The model also covers short and long transfers that must leave the command unchanged, and faults that arrive while a transfer is capturing its snapshot.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
   // Number of direct-drive inputs feeding the gate map.
   localparam int DIRECT_W = 3;
   // Channel count the mapping equations are written for.
   localparam int MAP_CH   = 6;
   // Synchronized serial pin bundle positions.
   localparam int PIN_CS   = 2;
   localparam int PIN_SCK  = 1;
   localparam int PIN_SDI  = 0;

   typedef struct packed {
      logic cs_fall;
      logic cs_rise;
      logic sck_rise;
      logic sck_fall;
   } spi_evt_t;
endpackage

// File: rtl/lsw_spi_port.sv
module lsw_spi_port
   import lsw_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cs_ni,
   input  logic              sclk_i,
   input  logic              sdi_i,
   input  logic [WORD_W-1:0] status_i,
   output logic [WORD_W-1:0] cmd_o,
   output logic              capture_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);
   localparam int CNT_W   = $clog2(WORD_W + 2);
   localparam int CNT_SAT = WORD_W + 1;

   logic [SYNC_STAGES-1:0][2:0] sync_q;
   logic [2:0]                  pins_s;
   logic                        cs_prev_q, sck_prev_q;
   spi_evt_t                    evt;
   logic [WORD_W-1:0]           rx_q, tx_q, cmd_q;
   logic [CNT_W-1:0]            cnt_q;

   // Synchronizer chain: every stage shifts one step per core clock.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= 3'b100;
      end else begin
         sync_q[0] <= {cs_ni, sclk_i, sdi_i};
         for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      end
   end

   assign pins_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cs_prev_q  <= 1'b1;
         sck_prev_q <= 1'b0;
      end else begin
         cs_prev_q  <= pins_s[PIN_CS];
         sck_prev_q <= pins_s[PIN_SCK];
      end
   end

   always_comb begin
      evt.cs_fall  = cs_prev_q & ~pins_s[PIN_CS];
      evt.cs_rise  = ~cs_prev_q & pins_s[PIN_CS];
      evt.sck_rise = ~sck_prev_q & pins_s[PIN_SCK] & ~pins_s[PIN_CS];
      evt.sck_fall = sck_prev_q & ~pins_s[PIN_SCK] & ~pins_s[PIN_CS];
   end

   // Receive side: shift, count, commit on a complete word.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_q  <= '0;
         cnt_q <= '0;
         cmd_q <= '0;
      end else begin
         if (evt.cs_fall) begin
            cnt_q <= '0;
         end else if (evt.sck_rise) begin
            rx_q <= {rx_q[WORD_W-2:0], pins_s[PIN_SDI]};
            if (cnt_q != CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
         end
         if (evt.cs_rise && cnt_q == CNT_W'(WORD_W)) cmd_q <= rx_q;
      end
   end

   // Transmit side: load snapshot at start, advance on falling clock.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_q <= '0;
      end else if (evt.cs_fall) begin
         tx_q <= status_i;
      end else if (evt.sck_fall) begin
         tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
   end

   assign cmd_o     = cmd_q;
   assign capture_o = evt.cs_fall;
   assign sdo_o     = tx_q[WORD_W-1];
   assign sdo_oe_o  = ~pins_s[PIN_CS];
endmodule

// File: rtl/lsw_fault_hold.sv
module lsw_fault_hold #(
   parameter int NUM_CH = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              capture_i,
   input  logic [NUM_CH-1:0] fault_i,
   output logic [NUM_CH-1:0] flags_o
);
   logic [NUM_CH-1:0] flags_q;

   // On capture the old flags leave with the snapshot; a pulse in the
   // same cycle re-arms its flag.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q <= '0;
      else if (capture_i) flags_q <= fault_i;
      else                flags_q <= flags_q | fault_i;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/lsw_gate_map.sv
module lsw_gate_map
   import lsw_pkg::*;
#(
   parameter int NUM_CH       = 6,
   parameter int WORD_W       = 8,
   parameter bit PAIR_MODE_EN = 1'b1
) (
   input  logic [WORD_W-1:0]   cmd_i,
   input  logic [DIRECT_W-1:0] direct_i,
   input  logic                inhibit_i,
   input  logic                pair_mode_i,
   output logic [NUM_CH-1:0]   gate_o,
   output logic                low_power_o
);
   localparam int SLEEP_BIT = WORD_W - 1;

   logic [NUM_CH-1:0] hex_v, pair_v, sel_v;
   logic              unused_bits;

   assign unused_bits = ^cmd_i[SLEEP_BIT-1:NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_hex
      if (c < DIRECT_W) begin : g_direct
         assign hex_v[c] = cmd_i[c] | direct_i[c];
      end else begin : g_cmd_only
         assign hex_v[c] = cmd_i[c];
      end
   end

   if (PAIR_MODE_EN) begin : g_pair
      logic grp_a, grp_b;
      assign grp_a  = direct_i[0] | (cmd_i[0] & cmd_i[4] & cmd_i[5]);
      assign grp_b  = direct_i[1] | (cmd_i[1] & cmd_i[2] & cmd_i[3]);
      assign pair_v = {grp_a, grp_a, grp_b, grp_b, grp_b, grp_a};
      assign sel_v  = pair_mode_i ? pair_v : hex_v;
   end else begin : g_hex_only
      logic unused_mode;
      assign unused_mode = pair_mode_i;
      assign pair_v      = hex_v;
      assign sel_v       = hex_v;
   end

   assign gate_o      = inhibit_i ? '0 : sel_v;
   assign low_power_o = inhibit_i & cmd_i[SLEEP_BIT];
endmodule

// File: rtl/lsw_ctrl_core.sv
module lsw_ctrl_core
   import lsw_pkg::*;
#(
   parameter int NUM_CH       = 6,
   parameter int WORD_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit PAIR_MODE_EN = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                spi_cs_ni,
   input  logic                spi_sclk_i,
   input  logic                spi_sdi_i,
   output logic                spi_sdo_o,
   output logic                spi_sdo_oe_o,
   input  logic [DIRECT_W-1:0] direct_on_i,
   input  logic                inhibit_i,
   input  logic                pair_mode_i,
   input  logic [NUM_CH-1:0]   fault_det_i,
   output logic [NUM_CH-1:0]   gate_on_o,
   output logic                low_power_o
);
   localparam int PAD_W = WORD_W - NUM_CH;

   if (NUM_CH != MAP_CH) begin : g_bad_ch
      $error("lsw_ctrl_core: NUM_CH must equal the mapped channel count");
   end
   if (WORD_W < NUM_CH + 2) begin : g_bad_word
      $error("lsw_ctrl_core: WORD_W too small for channels plus low-power bit");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lsw_ctrl_core: SYNC_STAGES must be at least 2");
   end

   logic [WORD_W-1:0] cmd_q;
   logic [WORD_W-1:0] status_w;
   logic [NUM_CH-1:0] flags_q;
   logic              capture;

   assign status_w = {{PAD_W{1'b0}}, flags_q};

   lsw_spi_port #(
      .WORD_W      (WORD_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_spi (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cs_ni     (spi_cs_ni),
      .sclk_i    (spi_sclk_i),
      .sdi_i     (spi_sdi_i),
      .status_i  (status_w),
      .cmd_o     (cmd_q),
      .capture_o (capture),
      .sdo_o     (spi_sdo_o),
      .sdo_oe_o  (spi_sdo_oe_o)
   );

   lsw_fault_hold #(
      .NUM_CH (NUM_CH)
   ) u_fault (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (capture),
      .fault_i   (fault_det_i),
      .flags_o   (flags_q)
   );

   lsw_gate_map #(
      .NUM_CH       (NUM_CH),
      .WORD_W       (WORD_W),
      .PAIR_MODE_EN (PAIR_MODE_EN)
   ) u_map (
      .cmd_i       (cmd_q),
      .direct_i    (direct_on_i),
      .inhibit_i   (inhibit_i),
      .pair_mode_i (pair_mode_i),
      .gate_o      (gate_on_o),
      .low_power_o (low_power_o)
   );
endmodule

// File: rtl/lsw_ctrl_core_chk.sv
module lsw_ctrl_core_chk #(
   parameter int NUM_CH       = 6,
   parameter int WORD_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit PAIR_MODE_EN = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              spi_cs_ni,
   input logic              spi_sdo_oe_o,
   input logic              inhibit_i,
   input logic              pair_mode_i,
   input logic [NUM_CH-1:0] fault_det_i,
   input logic [NUM_CH-1:0] gate_on_o,
   input logic              low_power_o,
   input logic [WORD_W-1:0] cmd_q,
   input logic [NUM_CH-1:0] flags_q
);
   localparam int LIM = SYNC_STAGES + 2;

   logic [15:0] hi_cnt, lo_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_cnt <= '0;
         lo_cnt <= '0;
      end else if (spi_cs_ni) begin
         lo_cnt <= '0;
         if (hi_cnt < 16'(LIM)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
         hi_cnt <= '0;
         if (lo_cnt < 16'(LIM)) lo_cnt <= lo_cnt + 1'b1;
      end
   end

   assert_inhibit_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inhibit_i |-> gate_on_o == '0);

   assert_lowpwr_needs_inhibit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      low_power_o |-> inhibit_i);

   assert_sdo_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hi_cnt >= 16'(LIM)) |-> !spi_sdo_oe_o);

   assert_cmd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lo_cnt >= 16'(LIM)) |-> $stable(cmd_q));

   assert_hex_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pair_mode_i && !inhibit_i) |-> gate_on_o[5:3] == cmd_q[5:3]);

   assert_group_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (PAIR_MODE_EN && pair_mode_i && !inhibit_i) |->
         (gate_on_o[0] == gate_on_o[4] && gate_on_o[4] == gate_on_o[5]));

   assert_group_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (PAIR_MODE_EN && pair_mode_i && !inhibit_i) |->
         (gate_on_o[1] == gate_on_o[2] && gate_on_o[2] == gate_on_o[3]));

   assert_fault_sticks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_det_i != '0) |=> ((flags_q & $past(fault_det_i)) == $past(fault_det_i)));
endmodule

bind lsw_ctrl_core lsw_ctrl_core_chk #(
   .NUM_CH       (NUM_CH),
   .WORD_W       (WORD_W),
   .SYNC_STAGES  (SYNC_STAGES),
   .PAIR_MODE_EN (PAIR_MODE_EN)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .spi_cs_ni    (spi_cs_ni),
   .spi_sdo_oe_o (spi_sdo_oe_o),
   .inhibit_i    (inhibit_i),
   .pair_mode_i  (pair_mode_i),
   .fault_det_i  (fault_det_i),
   .gate_on_o    (gate_on_o),
   .low_power_o  (low_power_o),
   .cmd_q        (cmd_q),
   .flags_q      (flags_q)
);

// File: tb/lsw_ctrl_core_bench.sv
module lsw_ctrl_core_bench;
   localparam int S    = 3;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic       sdo, sdo_oe;
   logic [2:0] direct = '0;
   logic       inhibit = 1'b0, pair = 1'b0;
   logic [5:0] fault = '0;
   logic [5:0] gate;
   logic       lowp;

   int tests = 0, fails = 0;
   int pend = 0;
   logic [7:0] pend_word = '0;
   logic [7:0] m_cmd = '0;
   logic [5:0] m_flags = '0;
   logic [7:0] got;

   always #5 clk = ~clk;

   lsw_ctrl_core #(.SYNC_STAGES(S)) u_lsw_ctrl_core (
      .clk_i(clk), .rst_ni(rst_n), .spi_cs_ni(cs_n), .spi_sclk_i(sclk),
      .spi_sdi_i(sdi), .spi_sdo_o(sdo), .spi_sdo_oe_o(sdo_oe),
      .direct_on_i(direct), .inhibit_i(inhibit), .pair_mode_i(pair),
      .fault_det_i(fault), .gate_on_o(gate), .low_power_o(lowp));

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [5:0] ref_gates(logic [7:0] c, logic [2:0] p, logic inh, logic pm);
      logic a, b;
      if (inh) return 6'd0;
      if (pm) begin
         a = p[0] || (c[0] && c[4] && c[5]);
         b = p[1] || (c[1] && c[2] && c[3]);
         return {a, a, b, b, b, a};
      end
      return {c[5:3], c[2:0] | p};
   endfunction

   // Per-clock comparison against the reference model.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (pend > 0) begin
            pend--;
            if (pend == 0) m_cmd = pend_word;
         end
         chk(gate == ref_gates(m_cmd, direct, inhibit, pair),
             inhibit ? "R6" : (pair ? "R4/R5" : "R2/R3"),
             gate, ref_gates(m_cmd, direct, inhibit, pair));
         chk(lowp == (inhibit && m_cmd[7]), "R7", lowp, inhibit && m_cmd[7]);
      end
   end

   task automatic xfer(input logic [7:0] word, input int nclk, output logic [7:0] rd);
      rd = '0;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      chk(sdo_oe == 1'b1, "R9", sdo_oe, 1);
      for (int i = 0; i < nclk; i++) begin
         sdi = (i < 8) ? word[7-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < 8) rd[7-i] = sdo;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      if (nclk == 8) begin
         pend_word = word;
         pend = S + 1;
      end
      repeat (HALF + S + 4) @(negedge clk);
      chk(sdo_oe == 1'b0, "R9", sdo_oe, 0);
   endtask

   task automatic send(input logic [7:0] word);
      logic [7:0] rd;
      xfer(word, 8, rd);
      chk(rd == {2'b00, m_flags}, "R10", rd, {2'b00, m_flags});
      m_flags = fault;
   endtask

   task automatic pulse(input logic [5:0] v);
      @(negedge clk) fault = v;
      m_flags |= v;
      @(negedge clk) fault = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(gate == 6'd0, "R1", gate, 0);
      chk(lowp == 1'b0, "R1", lowp, 0);
      chk(sdo_oe == 1'b0, "R1", sdo_oe, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(gate == 6'd0, "R1", gate, 0);

      // R3: independent upper channels, R2: direct OR on lower ones
      send(8'h38);
      chk(gate == 6'h38, "R3", gate, 6'h38);
      direct = 3'b101;
      @(negedge clk);
      chk(gate == 6'h3D, "R2", gate, 6'h3D);
      send(8'h02);
      chk(gate == 6'h07, "R2", gate, 6'h07);
      direct = 3'b000;
      @(negedge clk);
      chk(gate == 6'h02, "R2", gate, 6'h02);

      // R8: wrong clock counts leave the command alone
      xfer(8'hFF, 7, rd);
      chk(gate == 6'h02, "R8", gate, 6'h02);
      xfer(8'hFF, 9, rd);
      chk(gate == 6'h02, "R8", gate, 6'h02);
      send(8'h15);
      chk(gate == 6'h15, "R8", gate, 6'h15);

      // R4/R5: paired groups
      pair = 1'b1;
      send(8'h31);
      chk(gate == 6'h31, "R4", gate, 6'h31);
      send(8'h11);
      chk(gate == 6'h00, "R4", gate, 6'h00);
      direct = 3'b001;
      @(negedge clk);
      chk(gate == 6'h31, "R4", gate, 6'h31);
      direct = 3'b100;
      @(negedge clk);
      chk(gate == 6'h00, "R5", gate, 6'h00);
      send(8'h0E);
      chk(gate == 6'h0E, "R5", gate, 6'h0E);
      direct = 3'b010;
      send(8'h06);
      chk(gate == 6'h0E, "R5", gate, 6'h0E);
      direct = 3'b000;
      @(negedge clk);
      chk(gate == 6'h00, "R5", gate, 6'h00);
      pair = 1'b0;

      // R6/R7: inhibit and low-power
      send(8'hBF);
      direct = 3'b111;
      inhibit = 1'b1;
      @(negedge clk);
      chk(gate == 6'h00, "R6", gate, 0);
      chk(lowp == 1'b1, "R7", lowp, 1);
      send(8'h3F);
      chk(lowp == 1'b0, "R7", lowp, 0);
      inhibit = 1'b0;
      direct = 3'b000;
      @(negedge clk);
      chk(gate == 6'h3F, "R6", gate, 6'h3F);

      // R10/R11: fault flags
      pulse(6'h21);
      send(8'h00);
      chk(m_flags == 6'h00, "R11", m_flags, 0);
      send(8'h00);
      pulse(6'h12);
      pulse(6'h01);
      xfer(8'h00, 8, rd);
      chk(rd == 8'h13, "R10", rd, 8'h13);
      m_flags = '0;
      xfer(8'h00, 8, rd);
      chk(rd == 8'h00, "R11", rd, 8'h00);
      @(negedge clk) fault = 6'h04;
      m_flags |= 6'h04;
      send(8'h00);
      send(8'h00);
      @(negedge clk) fault = '0;
      xfer(8'h00, 8, rd);
      chk(rd == 8'h04, "R11", rd, 8'h04);
      xfer(8'h00, 8, rd);
      chk(rd == 8'h00, "R11", rd, 8'h00);

      repeat (10) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule